// File: doc/BRIEF.md
# Interrupt Status Queue Manager

This block keeps an ordered record of interrupt events. Each record goes into a 64-word circular queue held in an external RAM. For every cycle in which at least one enabled event fires, the block writes an entry of two words. The first word is a vector with one bit per event that caused the entry. The second word is a pointer: the current descriptor stack address for entries that carry message events, and zero for entries that carry only non-message events. The host reads the queue pointer and walks back through the queue to find the history.

The host loads the queue pointer through a write strobe. After that, the block advances the pointer by one for every word it writes, modulo the queue depth. Message-related event bits can be dropped separately for valid messages and for invalid messages by two configuration bits, on top of a per-bit enable mask. Non-message events ignore those two configuration bits. Each completed entry raises a one-cycle interrupt request. When an entry's second word lands in the last queue word, the block also raises a one-cycle rollover pulse.

Top module: `isq_mgr`

## Requirements
- R1: After the asynchronous reset, `ram_we_o`, `irq_o` and `qroll_o` are 0 and `ptr_o` is 0.
- R2: When `ptr_we_i` is high at a clock edge, `ptr_o` takes `ptr_wdata_i` on that edge. Otherwise, each cycle with `ram_we_o` high advances `ptr_o` by one, modulo 64. `ram_addr_o` always equals `ptr_o`.
- R3: An event bit whose bit in `evt_en_i` is 0 is ignored. A cycle with no enabled event bit writes nothing and leaves `ptr_o` unchanged.
- R4: An entry takes two consecutive write cycles, starting on the edge after the event cycle. The first word is the zero-extended OR of all enabled event bits seen in that cycle. The second word is `desc_ptr_i`, as sampled in the event cycle, whenever the vector holds a message bit.
- R5: Bits 8 to 11 of `evt_i` are non-message events. An entry whose vector holds only such bits has 0x0000 as its second word.
- R6: With `cfg_i` bit 7 set and `msg_valid_i` high, the message bits (0 to 7) of `evt_i` are ignored for that cycle. Non-message bits are still queued.
- R7: With `cfg_i` bit 8 set and `msg_invalid_i` high, the message bits of `evt_i` are ignored for that cycle. Bit 7 alone does not filter invalid messages.
- R8: `qroll_o` pulses for one cycle, together with `irq_o`, when an entry's second word was written at address 63.
- R9: Enabled events that arrive while an entry is being written are ORed together. They form the next entry, which starts right after the current one with no idle cycle.
- R10: `irq_o` is high for exactly one cycle, the cycle after each entry's second word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 12 | Event bits for this cycle; bits 0-7 are message events, bits 8-11 non-message |
| evt_en_i | input | 12 | Per-bit event enable (1 = enabled) |
| msg_valid_i | input | 1 | The message behind this cycle's message events was valid |
| msg_invalid_i | input | 1 | The message behind this cycle's message events was invalid |
| desc_ptr_i | input | 16 | Current descriptor stack address |
| cfg_i | input | 16 | Configuration; bit 7 drops valid-message events, bit 8 drops invalid-message events |
| ptr_we_i | input | 1 | Host write strobe for the queue pointer |
| ptr_wdata_i | input | 6 | Host value for the queue pointer |
| ram_we_o | output | 1 | RAM write request |
| ram_addr_o | output | 6 | RAM word address inside the queue |
| ram_wdata_o | output | 16 | RAM write data |
| ptr_o | output | 6 | Current queue pointer |
| irq_o | output | 1 | One-cycle interrupt request per completed entry |
| qroll_o | output | 1 | One-cycle queue rollover pulse |

## Verification
The main path is driven with a lone non-message bit, a lone message bit, and a message and a non-message bit together. These tell apart the vector ORing and the two ways the pointer word is chosen. The same mixed pattern is sent under each filter bit with the valid flag and then the invalid flag. The result shows that each filter bit strips only the message bits it covers. A pattern with only disabled bits must leave the RAM untouched. Two events in adjacent cycles show that a second event is merged into a following entry and not lost. An entry started at address 62 shows the wrap to 0 and the rollover pulse.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VEC  = 2'd1,
    ST_PTR  = 2'd2
  } isq_state_e;
endpackage

// File: rtl/isq_filter.sv
module isq_filter #(
  parameter int          EVT_W    = 12,
  parameter logic [11:0] MSG_MASK = 12'h0ff
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] en_i,
  input  logic             msg_valid_i,
  input  logic             msg_invalid_i,
  input  logic             drop_valid_i,
  input  logic             drop_invalid_i,
  output logic [EVT_W-1:0] vec_o,
  output logic             has_msg_o
);
  localparam logic [EVT_W-1:0] MsgBits = EVT_W'(MSG_MASK);

  logic msg_keep;

  always_comb begin
    msg_keep  = !((msg_valid_i && drop_valid_i) || (msg_invalid_i && drop_invalid_i));
    vec_o     = evt_i & en_i & (msg_keep ? {EVT_W{1'b1}} : ~MsgBits);
    has_msg_o = |(vec_o & MsgBits);
  end
endmodule

// File: rtl/isq_ptr.sv
module isq_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              at_last_o
);
  localparam logic [ADDR_W-1:0] LastAddr = {ADDR_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;  // host write wins
    else if (inc_i)  ptr_o <= ptr_o + 1'b1; // natural modulo 2**ADDR_W
  end

  assign at_last_o = (ptr_o == LastAddr);
endmodule

// File: rtl/isq_seq.sv
module isq_seq
  import isq_pkg::*;
#(
  parameter int EVT_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  vec_i,
  input  logic              has_msg_i,
  input  logic [DATA_W-1:0] desc_i,
  output isq_state_e        state_o,
  output logic [EVT_W-1:0]  ent_vec_o,
  output logic [DATA_W-1:0] ent_ptr_o
);
  isq_state_e        state_q;
  logic [EVT_W-1:0]  pend_vec_q;
  logic              pend_msg_q;
  logic [DATA_W-1:0] pend_desc_q;
  logic [EVT_W-1:0]  merged;
  logic [DATA_W-1:0] merged_ptr;

  always_comb begin
    merged = pend_vec_q | vec_i;
    if (has_msg_i)       merged_ptr = desc_i;
    else if (pend_msg_q) merged_ptr = pend_desc_q;
    else                 merged_ptr = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ent_vec_o   <= '0;
      ent_ptr_o   <= '0;
      pend_vec_q  <= '0;
      pend_msg_q  <= 1'b0;
      pend_desc_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (|vec_i) begin
          ent_vec_o <= vec_i;
          ent_ptr_o <= has_msg_i ? desc_i : '0;
          state_q   <= ST_VEC;
        end
        ST_VEC: begin
          // collect events arriving mid-entry
          pend_vec_q <= pend_vec_q | vec_i;
          if (has_msg_i) begin
            pend_msg_q  <= 1'b1;
            pend_desc_q <= desc_i;
          end
          state_q <= ST_PTR;
        end
        ST_PTR: begin
          pend_vec_q <= '0;
          pend_msg_q <= 1'b0;
          if (|merged) begin
            ent_vec_o <= merged;
            ent_ptr_o <= merged_ptr;
            state_q   <= ST_VEC;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/isq_mgr.sv
module isq_mgr
  import isq_pkg::*;
#(
  parameter int          EVT_W    = 12,
  parameter int          DATA_W   = 16,
  parameter int          Q_WORDS  = 64,
  parameter logic [11:0] MSG_MASK = 12'h0ff,
  parameter int          DROP_VALID_BIT   = 7,
  parameter int          DROP_INVALID_BIT = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [EVT_W-1:0]           evt_i,
  input  logic [EVT_W-1:0]           evt_en_i,
  input  logic                       msg_valid_i,
  input  logic                       msg_invalid_i,
  input  logic [DATA_W-1:0]          desc_ptr_i,
  input  logic [DATA_W-1:0]          cfg_i,
  input  logic                       ptr_we_i,
  input  logic [$clog2(Q_WORDS)-1:0] ptr_wdata_i,
  output logic                       ram_we_o,
  output logic [$clog2(Q_WORDS)-1:0] ram_addr_o,
  output logic [DATA_W-1:0]          ram_wdata_o,
  output logic [$clog2(Q_WORDS)-1:0] ptr_o,
  output logic                       irq_o,
  output logic                       qroll_o
);
  localparam int ADDR_W = $clog2(Q_WORDS);

  logic [EVT_W-1:0]  vec;
  logic              has_msg;
  isq_state_e        state_q;
  logic [EVT_W-1:0]  ent_vec;
  logic [DATA_W-1:0] ent_ptr;
  logic              at_last;

  isq_filter #(.EVT_W(EVT_W), .MSG_MASK(MSG_MASK)) u_filter (
    .evt_i          (evt_i),
    .en_i           (evt_en_i),
    .msg_valid_i    (msg_valid_i),
    .msg_invalid_i  (msg_invalid_i),
    .drop_valid_i   (cfg_i[DROP_VALID_BIT]),
    .drop_invalid_i (cfg_i[DROP_INVALID_BIT]),
    .vec_o          (vec),
    .has_msg_o      (has_msg)
  );

  isq_seq #(.EVT_W(EVT_W), .DATA_W(DATA_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vec_i     (vec),
    .has_msg_i (has_msg),
    .desc_i    (desc_ptr_i),
    .state_o   (state_q),
    .ent_vec_o (ent_vec),
    .ent_ptr_o (ent_ptr)
  );

  isq_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_we_i),
    .load_val_i (ptr_wdata_i),
    .inc_i      (ram_we_o),
    .ptr_o      (ptr_o),
    .at_last_o  (at_last)
  );

  assign ram_we_o    = (state_q != ST_IDLE);
  assign ram_addr_o  = ptr_o;
  assign ram_wdata_o = (state_q == ST_VEC) ? DATA_W'(ent_vec) : ent_ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o   <= 1'b0;
      qroll_o <= 1'b0;
    end else begin
      irq_o   <= (state_q == ST_PTR);
      qroll_o <= (state_q == ST_PTR) && at_last;
    end
  end
endmodule

// File: rtl/isq_mgr_chk.sv
module isq_mgr_chk
  import isq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ram_we_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic [DATA_W-1:0] ram_wdata_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic              ptr_we_i,
  input logic              irq_o,
  input logic              qroll_o,
  input isq_state_e        state
);
  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && !ptr_we_i) |=> (ptr_o == ADDR_W'($past(ram_addr_o) + 1'b1)));

  assert_second_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_VEC && !ptr_we_i) |=> (ram_we_o && ram_addr_o == ADDR_W'($past(ram_addr_o) + 1'b1)));

  assert_vec_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_VEC) |-> (ram_wdata_o != '0));

  assert_irq_after_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ram_we_o));

  assert_irq_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_qroll_at_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qroll_o |-> (irq_o && $past(ram_addr_o) == {ADDR_W{1'b1}}));
endmodule

bind isq_mgr isq_mgr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ram_we_o    (ram_we_o),
  .ram_addr_o  (ram_addr_o),
  .ram_wdata_o (ram_wdata_o),
  .ptr_o       (ptr_o),
  .ptr_we_i    (ptr_we_i),
  .irq_o       (irq_o),
  .qroll_o     (qroll_o),
  .state       (state_q)
);

// File: tb/isq_mgr_tb_top.sv
module isq_mgr_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] evt_i = '0;
  logic [11:0] evt_en_i = 12'hfff;
  logic        msg_valid_i = 1'b0;
  logic        msg_invalid_i = 1'b0;
  logic [15:0] desc_ptr_i = '0;
  logic [15:0] cfg_i = '0;
  logic        ptr_we_i = 1'b0;
  logic [5:0]  ptr_wdata_i = '0;
  logic        ram_we_o;
  logic [5:0]  ram_addr_o;
  logic [15:0] ram_wdata_o;
  logic [5:0]  ptr_o;
  logic        irq_o;
  logic        qroll_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  isq_mgr dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic clear_evt();
    evt_i = '0; msg_valid_i = 1'b0; msg_invalid_i = 1'b0;
  endtask

  task automatic load_ptr(logic [5:0] v);
    ptr_we_i = 1'b1; ptr_wdata_i = v;
    step();
    ptr_we_i = 1'b0;
    check("R2 host load", ptr_o, v);
  endtask

  // one event cycle, then check both words, irq and final pointer
  task automatic one_entry(string tag, logic [11:0] ev, logic mv, logic mi,
                           logic [15:0] desc, logic [15:0] exp_vec,
                           logic [15:0] exp_ptr);
    logic [5:0] p;
    p = ptr_o;
    evt_i = ev; msg_valid_i = mv; msg_invalid_i = mi; desc_ptr_i = desc;
    step();
    clear_evt(); desc_ptr_i = 16'hdead;
    check({tag, " R4 we1"}, ram_we_o, 1);
    check({tag, " R2 addr1"}, ram_addr_o, p);
    check({tag, " R4 vec"}, ram_wdata_o, exp_vec);
    step();
    check({tag, " R4 we2"}, ram_we_o, 1);
    check({tag, " R2 addr2"}, ram_addr_o, 6'(p + 1));
    check({tag, " R4 ptrword"}, ram_wdata_o, exp_ptr);
    check({tag, " R10 irq early"}, irq_o, 0);
    step();
    check({tag, " R10 irq"}, irq_o, 1);
    check({tag, " R2 ptr"}, ptr_o, 6'(p + 2));
    check({tag, " idle"}, ram_we_o, 0);
    check({tag, " R8 qroll"}, qroll_o, (p == 6'd62));
    step();
    check({tag, " R10 irq one cycle"}, irq_o, 0);
  endtask

  task automatic no_entry(string tag, logic [11:0] ev, logic mv, logic mi);
    logic [5:0] p;
    p = ptr_o;
    evt_i = ev; msg_valid_i = mv; msg_invalid_i = mi; desc_ptr_i = 16'h1111;
    step();
    clear_evt();
    repeat (3) begin
      check({tag, " no write"}, ram_we_o, 0);
      step();
    end
    check({tag, " ptr kept"}, ptr_o, p);
    check({tag, " no irq"}, irq_o, 0);
  endtask

  task automatic t_reset();
    check("R1 we", ram_we_o, 0);
    check("R1 ptr", ptr_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 qroll", qroll_o, 0);
  endtask

  task automatic t_basic();
    load_ptr(6'd10);
    one_entry("R5 nonmsg", 12'h400, 0, 0, 16'h1234, 16'h0400, 16'h0000);
    one_entry("R4 msg", 12'h003, 1, 0, 16'h1234, 16'h0003, 16'h1234);
    one_entry("R4 mixed OR", 12'h281, 0, 1, 16'h0abc, 16'h0281, 16'h0abc);
  endtask

  task automatic t_mask();
    evt_en_i = 12'h0f0;
    no_entry("R3 masked", 12'h30f, 1, 0);
    one_entry("R3 partial", 12'h31f, 1, 0, 16'h0042, 16'h0010, 16'h0042);
    evt_en_i = 12'hfff;
  endtask

  task automatic t_filter();
    cfg_i = 16'h0080;
    one_entry("R6 valid dropped", 12'h801, 1, 0, 16'h5555, 16'h0800, 16'h0000);
    no_entry("R6 msg only", 12'h0ff, 1, 0);
    one_entry("R7 bit7 keeps invalid", 12'h010, 0, 1, 16'h7777, 16'h0010, 16'h7777);
    cfg_i = 16'h0100;
    one_entry("R7 invalid dropped", 12'h102, 0, 1, 16'h6666, 16'h0100, 16'h0000);
    one_entry("R6 bit8 keeps valid", 12'h002, 1, 0, 16'h3333, 16'h0002, 16'h3333);
    cfg_i = 16'h0000;
  endtask

  task automatic t_wrap();
    load_ptr(6'd62);
    one_entry("R8 wrap", 12'h004, 1, 0, 16'h0e0e, 16'h0004, 16'h0e0e);
    check("R8 ptr zero", ptr_o, 0);
  endtask

  task automatic t_merge();
    logic [5:0] p;
    load_ptr(6'd20);
    p = ptr_o;
    evt_i = 12'h001; msg_valid_i = 1'b1; desc_ptr_i = 16'h00a0;
    step();
    evt_i = 12'h200; msg_valid_i = 1'b0; desc_ptr_i = 16'h00b0;
    check("R9 first vec", ram_wdata_o, 16'h0001);
    step();
    evt_i = 12'h004; msg_valid_i = 1'b1; desc_ptr_i = 16'h00c0;
    check("R9 first ptr", ram_wdata_o, 16'h00a0);
    step();
    clear_evt(); desc_ptr_i = 16'hffff;
    check("R9 second addr", ram_addr_o, 6'(p + 2));
    check("R9 merged vec", ram_wdata_o, 16'h0204);
    check("R10 irq first", irq_o, 1);
    step();
    check("R9 merged ptr", ram_wdata_o, 16'h00c0);
    check("R10 irq gap", irq_o, 0);
    step();
    check("R9 done", ram_we_o, 0);
    check("R9 ptr", ptr_o, 6'(p + 4));
    check("R10 irq second", irq_o, 1);
    step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_basic();
    t_mask();
    t_filter();
    t_wrap();
    t_merge();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule